// File: doc/BRIEF.md
# Checkerboard Grid Cursor Pixel Shader

This block produces the colour of every pixel on a 640x480 display. The screen is divided into square cells of 32x32 pixels, giving 20 columns and 15 rows. The cells alternate between green and blue like a chessboard, and one cell, the cursor, is painted red instead. An external video timing generator supplies the current pixel coordinates and a blanking flag. This block returns the RGB levels one clock later.

Four raw pushbutton inputs move the cursor by one cell up, down, right or left. Each button passes through its own synchronizer, and the cursor steps once on each press, however long the button is held. The cursor wraps around at every edge, so the grid behaves like a torus. An active-high reset puts the cursor back in the top-left cell.

Top module: `grid_cursor_top`

## Requirements
- R1: While `rst` is high, every colour output is 0. After reset the cursor is at column 0, row 0.
- R2: The cell column is `px_x[9:5]` and the cell row is `px_y[8:5]`. Inside the grid, a non-cursor cell is green (r=0, g=15, b=0) when column+row is even and blue (r=0, g=0, b=15) when it is odd.
- R3: The cell under the cursor is red (r=15, g=0, b=0).
- R4: When `px_blank` is high, all colour outputs are 0.
- R5: `btn_raw[0]` (up) decrements the cursor row, and row 0 wraps to row 14.
- R6: `btn_raw[1]` (down) increments the cursor row, and row 14 wraps to row 0.
- R7: `btn_raw[2]` (right) increments the cursor column, and column 19 wraps to column 0.
- R8: `btn_raw[3]` (left) decrements the cursor column, and column 0 wraps to column 19.
- R9: Each rising edge of a raw button moves the cursor once, and holding the button does not repeat the move. The cursor register changes on the third rising clock edge after the raw level rises.
- R10: If up and down rise in the same cycle, they cancel and the row is kept. The same holds for left and right on the column. A vertical move and a horizontal move in the same cycle are both applied.
- R11: Pixels with `px_x` >= 640 or `px_y` >= 480 are black.
- R12: The colour outputs are registered. The outputs seen after a clock edge describe the coordinates, blank flag and cursor that were present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| px_x | input | 10 | Current pixel column |
| px_y | input | 9 | Current pixel row |
| px_blank | input | 1 | High outside the visible region |
| btn_raw | input | 4 | Raw buttons: bit0 up, bit1 down, bit2 right, bit3 left |
| vid_r | output | 4 | Red level |
| vid_g | output | 4 | Green level |
| vid_b | output | 4 | Blue level |

## Verification
On every cycle the assertions check the following: the return to the home cell after reset, blanking forcing black, and the cursor staying inside the grid. They also check the four wrap transitions, that a move pulse never lasts two cycles, that the cursor holds without a pulse, and that opposing moves cancel. The checkerboard parity, the red cursor cell and the black region beyond the grid depend on pixel coordinates. The exact three-edge button latency and the single step while a button is held only show up at the outputs. These are shown by the bench, which runs random pixel sweeps, random button masks and directed walks across each edge against its own model.

// File: rtl/grid_pkg.sv
package grid_pkg;

  // Button bit positions (decoded by the cursor register)
  localparam int BTN_UP    = 0;
  localparam int BTN_DOWN  = 1;
  localparam int BTN_RIGHT = 2;
  localparam int BTN_LEFT  = 3;
  localparam int BTN_COUNT = 4;

  typedef enum logic [1:0] {
    SHADE_BLACK = 2'd0,
    SHADE_GREEN = 2'd1,
    SHADE_BLUE  = 2'd2,
    SHADE_RED   = 2'd3
  } shade_e;

  // Odd parity of (column + row) only depends on the low bits
  function automatic logic cell_is_odd(input logic col_lsb, input logic row_lsb);
    return col_lsb ^ row_lsb;
  endfunction

  // Pick the shade for one pixel
  function automatic shade_e pick_shade(input logic in_grid, input logic is_cursor,
                                        input logic odd);
    if (!in_grid)  return SHADE_BLACK;
    if (is_cursor) return SHADE_RED;
    return odd ? SHADE_BLUE : SHADE_GREEN;
  endfunction

endpackage

// File: rtl/grid_btn_edge.sv
module grid_btn_edge #(
  parameter int N_BTN = 4,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] raw,
  output logic [N_BTN-1:0] rise
);

  localparam int SH_W = SYNC + 1;

  for (genvar g = 0; g < N_BTN; g++) begin : g_btn
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], raw[g]};
    end
    // rising edge of the synchronized level against its delayed copy
    assign rise[g] = sh[SYNC-1] & ~sh[SYNC];
  end

endmodule

// File: rtl/grid_cursor_pos.sv
module grid_cursor_pos #(
  parameter int COLS  = 20,
  parameter int ROWS  = 15,
  parameter int COL_W = 5,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       step,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  import grid_pkg::*;

  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

  function automatic logic [COL_W-1:0] col_next(input logic [COL_W-1:0] c,
                                                input logic inc, input logic dec);
    if (inc && !dec) return (c == COL_MAX) ? '0 : c + 1'b1;
    if (dec && !inc) return (c == '0) ? COL_MAX : c - 1'b1;
    return c;
  endfunction

  function automatic logic [ROW_W-1:0] row_next(input logic [ROW_W-1:0] r,
                                                input logic inc, input logic dec);
    if (inc && !dec) return (r == ROW_MAX) ? '0 : r + 1'b1;
    if (dec && !inc) return (r == '0) ? ROW_MAX : r - 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= col_next(col, step[BTN_RIGHT], step[BTN_LEFT]);
      row <= row_next(row, step[BTN_DOWN], step[BTN_UP]);
    end
  end

endmodule

// File: rtl/grid_pixel_shade.sv
module grid_pixel_shade #(
  parameter int X_W      = 10,
  parameter int Y_W      = 9,
  parameter int CELL_LG  = 5,
  parameter int COLS     = 20,
  parameter int ROWS     = 15,
  parameter int COLOR_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [X_W-1:0]         px_x,
  input  logic [Y_W-1:0]         px_y,
  input  logic                   blank,
  input  logic [X_W-CELL_LG-1:0] cur_col,
  input  logic [Y_W-CELL_LG-1:0] cur_row,
  output logic [COLOR_W-1:0]     r,
  output logic [COLOR_W-1:0]     g,
  output logic [COLOR_W-1:0]     b
);
  import grid_pkg::*;

  localparam int XC_W = X_W - CELL_LG;
  localparam int YC_W = Y_W - CELL_LG;
  localparam logic [XC_W-1:0] COL_LIM = XC_W'(COLS);
  localparam logic [YC_W-1:0] ROW_LIM = YC_W'(ROWS);
  localparam logic [COLOR_W-1:0] FULL = '1;

  logic [XC_W-1:0] pcol;
  logic [YC_W-1:0] prow;
  logic            in_grid;
  logic            on_cursor;
  shade_e          shade;

  assign pcol      = px_x[X_W-1:CELL_LG];
  assign prow      = px_y[Y_W-1:CELL_LG];
  assign in_grid   = (pcol < COL_LIM) && (prow < ROW_LIM) && !blank;
  assign on_cursor = (pcol == cur_col) && (prow == cur_row);
  assign shade     = pick_shade(in_grid, on_cursor, cell_is_odd(pcol[0], prow[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      r <= '0;
      g <= '0;
      b <= '0;
    end else begin
      r <= (shade == SHADE_RED)   ? FULL : '0;
      g <= (shade == SHADE_GREEN) ? FULL : '0;
      b <= (shade == SHADE_BLUE)  ? FULL : '0;
    end
  end

endmodule

// File: rtl/grid_cursor_top.sv
module grid_cursor_top #(
  parameter int X_W     = 10,
  parameter int Y_W     = 9,
  parameter int CELL_LG = 5,
  parameter int COLS    = 20,
  parameter int ROWS    = 15,
  parameter int COLOR_W = 4,
  parameter int SYNC    = 2
) (
  input  logic               clk_pix,
  input  logic               rst,
  input  logic [X_W-1:0]     px_x,
  input  logic [Y_W-1:0]     px_y,
  input  logic               px_blank,
  input  logic [3:0]         btn_raw,
  output logic [COLOR_W-1:0] vid_r,
  output logic [COLOR_W-1:0] vid_g,
  output logic [COLOR_W-1:0] vid_b
);
  import grid_pkg::*;

  localparam int XC_W = X_W - CELL_LG;
  localparam int YC_W = Y_W - CELL_LG;

  logic [BTN_COUNT-1:0] move_pulse;
  logic [XC_W-1:0]      cur_col;
  logic [YC_W-1:0]      cur_row;

  grid_btn_edge #(.N_BTN(BTN_COUNT), .SYNC(SYNC)) u_btn (
    .clk (clk_pix),
    .rst (rst),
    .raw (btn_raw),
    .rise(move_pulse)
  );

  grid_cursor_pos #(.COLS(COLS), .ROWS(ROWS), .COL_W(XC_W), .ROW_W(YC_W)) u_pos (
    .clk (clk_pix),
    .rst (rst),
    .step(move_pulse),
    .col (cur_col),
    .row (cur_row)
  );

  grid_pixel_shade #(
    .X_W(X_W), .Y_W(Y_W), .CELL_LG(CELL_LG),
    .COLS(COLS), .ROWS(ROWS), .COLOR_W(COLOR_W)
  ) u_shade (
    .clk    (clk_pix),
    .rst    (rst),
    .px_x   (px_x),
    .px_y   (px_y),
    .blank  (px_blank),
    .cur_col(cur_col),
    .cur_row(cur_row),
    .r      (vid_r),
    .g      (vid_g),
    .b      (vid_b)
  );

endmodule

// File: rtl/grid_cursor_chk.sv
module grid_cursor_chk #(
  parameter int COLS    = 20,
  parameter int ROWS    = 15,
  parameter int COL_W   = 5,
  parameter int ROW_W   = 4,
  parameter int COLOR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         pulse,
  input logic [COL_W-1:0]   col,
  input logic [ROW_W-1:0]   row,
  input logic               blank,
  input logic [COLOR_W-1:0] r,
  input logic [COLOR_W-1:0] g,
  input logic [COLOR_W-1:0] b
);
  localparam logic [COL_W-1:0] CMAX = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] RMAX = ROW_W'(ROWS - 1);

  AST_RESET_HOME: assert property (@(posedge clk) rst |=> (col == '0 && row == '0)); // R1
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst) blank |=> (r == '0 && g == '0 && b == '0)); // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst) row <= RMAX); // R6
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst) col <= CMAX); // R7
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst) (pulse[0] && !pulse[1] && row == '0) |=> row == RMAX); // R5
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst) (pulse[1] && !pulse[0] && row == RMAX) |=> row == '0); // R6
  AST_RIGHT_WRAP: assert property (@(posedge clk) disable iff (rst) (pulse[2] && !pulse[3] && col == CMAX) |=> col == '0); // R7
  AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (rst) (pulse[3] && !pulse[2] && col == '0) |=> col == CMAX); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) (pulse != 4'd0) |=> ((pulse & $past(pulse)) == 4'd0)); // R9
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst) (pulse == 4'd0) |=> ($stable(col) && $stable(row))); // R9
  AST_VERT_CANCEL: assert property (@(posedge clk) disable iff (rst) (pulse[0] && pulse[1]) |=> $stable(row)); // R10
  AST_HORZ_CANCEL: assert property (@(posedge clk) disable iff (rst) (pulse[2] && pulse[3]) |=> $stable(col)); // R10

endmodule

bind grid_cursor_top grid_cursor_chk #(
  .COLS(COLS), .ROWS(ROWS), .COL_W(XC_W), .ROW_W(YC_W), .COLOR_W(COLOR_W)
) u_chk (
  .clk  (clk_pix),
  .rst  (rst),
  .pulse(move_pulse),
  .col  (cur_col),
  .row  (cur_row),
  .blank(px_blank),
  .r    (vid_r),
  .g    (vid_g),
  .b    (vid_b)
);

// File: tb/grid_cursor_top_bench.sv
`timescale 1ns/1ps
module grid_cursor_top_bench;

  logic       clk_pix = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] px_x = '0;
  logic [8:0] px_y = '0;
  logic       px_blank = 1'b0;
  logic [3:0] btn_raw = '0;
  logic [3:0] vid_r, vid_g, vid_b;

  int n_cmp = 0;
  int n_bad = 0;
  int m_col = 0;
  int m_row = 0;
  bit done = 1'b0;

  always #2.5 clk_pix = ~clk_pix;

  grid_cursor_top u_grid_cursor_top (
    .clk_pix(clk_pix), .rst(rst), .px_x(px_x), .px_y(px_y), .px_blank(px_blank),
    .btn_raw(btn_raw), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
  );

  // Expected colour as {r,g,b}, from the requirements
  function automatic logic [11:0] want_rgb(int x, int y, bit blk, int cc, int cr);
    int c = x / 32;
    int rr = y / 32;
    if (blk || x >= 640 || y >= 480) return 12'h000;
    if (c == cc && rr == cr) return 12'hF00;
    if (((c + rr) % 2) == 0) return 12'h0F0;
    return 12'h00F;
  endfunction

  task automatic cmp(input logic [11:0] got, input logic [11:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got rgb=%h expected %h (cursor model %0d,%0d)", req, got, exp, m_col, m_row);
    end
  endtask

  task automatic check_px(input int x, input int y, input bit blk, input string req);
    @(negedge clk_pix);
    px_x = 10'(x); px_y = 9'(y); px_blank = blk;
    @(posedge clk_pix); #1;
    cmp({vid_r, vid_g, vid_b}, want_rgb(x, y, blk, m_col, m_row), req);
  endtask

  function automatic void model_apply(logic [3:0] m);
    if (m[0] && !m[1]) m_row = (m_row == 0) ? 14 : m_row - 1;
    if (m[1] && !m[0]) m_row = (m_row == 14) ? 0 : m_row + 1;
    if (m[2] && !m[3]) m_col = (m_col == 19) ? 0 : m_col + 1;
    if (m[3] && !m[2]) m_col = (m_col == 0) ? 19 : m_col - 1;
  endfunction

  task automatic press(input logic [3:0] m, input int hold);
    @(negedge clk_pix); btn_raw = m;
    repeat (hold) @(negedge clk_pix);
    btn_raw = '0;
    repeat (4) @(negedge clk_pix);
    model_apply(m);
  endtask

  task automatic check_cursor(input string req);
    check_px(m_col * 32 + 16, m_row * 32 + 16, 1'b0, req);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    // reset state
    repeat (3) @(posedge clk_pix);
    #1 cmp({vid_r, vid_g, vid_b}, 12'h000, "R1 outputs during reset");
    @(negedge clk_pix); rst = 1'b0;
    repeat (3) @(negedge clk_pix);
    check_px(5, 5, 1'b0, "R1 home cursor red");
    check_px(40, 5, 1'b0, "R2 cell (1,0) blue");
    check_px(40, 40, 1'b0, "R2 cell (1,1) green");
    check_px(639, 479, 1'b0, "R2 last cell (19,14) blue");
    check_px(5, 5, 1'b1, "R4 blank over cursor");
    check_px(700, 100, 1'b0, "R11 x beyond 639");
    check_px(100, 480, 1'b0, "R11 y beyond 479");
    check_px(1023, 511, 1'b0, "R11 far corner");

    // edge wraps
    press(4'b0001, 3);  check_cursor("R5 up wraps row 0 to 14");
    press(4'b0010, 5);  check_cursor("R6 down wraps row 14 to 0");
    press(4'b1000, 2);  check_cursor("R8 left wraps col 0 to 19");
    press(4'b0100, 7);  check_cursor("R7 right wraps col 19 to 0");
    press(4'b0011, 3);  check_cursor("R10 up+down cancel");
    press(4'b1100, 3);  check_cursor("R10 left+right cancel");
    press(4'b0110, 3);  check_cursor("R10 down+right both apply");
    check_px(16, 16, 1'b0, "R3 old cell back to checker");

    // latency and single step while held
    begin
      int tx = ((m_col == 19) ? 0 : m_col + 1) * 32 + 8;
      int ty = m_row * 32 + 8;
      @(negedge clk_pix);
      px_x = 10'(tx); px_y = 9'(ty); px_blank = 1'b0; btn_raw = 4'b0100;
      repeat (3) @(posedge clk_pix);
      #1 cmp({vid_r, vid_g, vid_b}, want_rgb(tx, ty, 0, m_col, m_row), "R9 no move before third edge");
      model_apply(4'b0100);
      @(posedge clk_pix);
      #1 cmp({vid_r, vid_g, vid_b}, want_rgb(tx, ty, 0, m_col, m_row), "R12 moved cursor seen one edge later");
      repeat (30) @(negedge clk_pix);
      btn_raw = '0;
      repeat (4) @(negedge clk_pix);
      check_cursor("R9 held button moved once");
      check_px(m_col * 32 + 48 > 639 ? 8 : m_col * 32 + 48, m_row * 32 + 8, 1'b0, "R9 no second step");
    end

    // random button traffic
    for (int i = 0; i < 80; i++) begin
      logic [3:0] m = 4'($urandom_range(1, 15));
      press(m, $urandom_range(1, 12));
      if (m[0] | m[1]) check_cursor("R5 R6 random vertical move");
      else             check_cursor("R7 R8 random horizontal move");
    end

    // random pixels
    for (int i = 0; i < 400; i++) begin
      int x = $urandom_range(0, 1023);
      int y = $urandom_range(0, 511);
      bit bl = ($urandom_range(0, 7) == 0);
      check_px(x, y, bl, "R2 R3 R4 R11 random pixel");
    end

    // reset mid-run returns home
    @(negedge clk_pix); rst = 1'b1;
    repeat (2) @(negedge clk_pix); rst = 1'b0;
    m_col = 0; m_row = 0;
    repeat (3) @(negedge clk_pix);
    check_cursor("R1 reset restores home");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule